// File: doc/BRIEF.md
# Eight-Operation 8-bit ALU

This block is the arithmetic and logic datapath of a small 8-bit processor. Each cycle it takes two 8-bit operands and a 3-bit operation code. It produces an 8-bit result together with a carry flag for addition and a borrow flag for subtraction.

The eight operations are:

- passing B through unchanged
- bitwise XOR, AND and OR
- unsigned addition and subtraction
- a logical right shift of B by one place
- an unsigned multiply of the low nibbles of both operands

Every operation is computed in parallel. A selector tree steered by the operation code picks one of the candidate results.

The result and both flags are captured in one output register with a synchronous active-high reset. Each answer therefore appears one clock edge after its inputs are sampled. Operands and operation code may change every cycle.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising edge, `res`, `cout` and `bout` become 0 after that edge.
- R2: Outputs show the result for the `op`, `a` and `b` sampled at the previous rising edge; a new operation may be issued every cycle.
- R3: Code 3'b000 gives `res` = `b`; `a` has no effect.
- R4: Code 3'b001 gives `a ^ b`, 3'b010 gives `a & b`, 3'b011 gives `a | b`, bit by bit.
- R5: Code 3'b100 gives `res` = low 8 bits of `a + b`, and `cout` = bit 8 of that unsigned sum.
- R6: Code 3'b101 gives `res` = `a - b` modulo 256, and `bout` = 1 exactly when `b` > `a` as unsigned values.
- R7: Code 3'b110 gives `res[7]` = 0 and `res[6:0]` = `b[7:1]`; `a` has no effect.
- R8: Code 3'b111 gives `res` = `a[3:0] * b[3:0]` as unsigned values, 8-bit product; bits 7..4 of both operands have no effect.
- R9: `cout` is 0 for every code other than 3'b100, and `bout` is 0 for every code other than 3'b101.
- R10: With `a` = `b` = 8'hAA, codes 0 through 7 give 8'hAA, 8'h00, 8'hAA, 8'hAA, 8'h54 with `cout` = 1, 8'h00 with `bout` = 0, 8'h55 and 8'h64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 3 | Operation code |
| a | input | 8 | First operand |
| b | input | 8 | Second operand, also the shift and pass source |
| res | output | 8 | Registered result |
| cout | output | 1 | Registered carry flag of the addition |
| bout | output | 1 | Registered borrow flag of the subtraction |

## Verification
The hardest situations to reach are the edges of the shared adder-subtractor. These are a carry out of bit 7 and a borrow at exactly `a` = `b`, which must give no borrow. A second hard case is the multiply with non-zero upper nibbles, where those bits must leave the result alone.

Random operands from a fixed seed rarely reach these points. So the stimulus adds directed pairs: 0x00, 0xFF, equal operands, `a` one below `b`, and the all-0xAA vector. It also issues multiply and shift pairs that differ only in the ignored bits, and compares their results.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPW = 3;
  localparam int NOPS = 1 << OPW;

  typedef enum logic [OPW-1:0] {
    OP_PASS = 3'b000,
    OP_XOR  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_ADD  = 3'b100,
    OP_SUB  = 3'b101,
    OP_SHR  = 3'b110,
    OP_MUL  = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
// Ripple adder shared by add and subtract: subtract inverts b and injects carry 1.
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_out
);
  logic [W-1:0] yy;
  logic [W:0]   c;

  assign yy   = y ^ {W{sub}};
  assign c[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]   = x[i] ^ yy[i] ^ c[i];
    assign c[i+1]   = (x[i] & yy[i]) | (c[i] & (x[i] ^ yy[i]));
  end

  assign c_out = c[W];
endmodule

// File: rtl/alu8_nibmul.sv
// Unsigned shift-and-add multiply of the low MW bits of each operand.
module alu8_nibmul #(
  parameter int W  = 8,
  parameter int MW = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] prod
);
  logic [W-1:0] acc [MW+1];
  logic [W-1:0] ylo;

  assign ylo    = W'(y[MW-1:0]);
  assign acc[0] = '0;

  for (genvar i = 0; i < MW; i++) begin : g_pp
    assign acc[i+1] = acc[i] + (x[i] ? (ylo << i) : '0);
  end

  assign prod = acc[MW];
endmodule

// File: rtl/alu8_seltree.sv
// Binary tree of 2:1 muxes; node k has children 2k and 2k+1, leaves at N..2N-1.
module alu8_seltree #(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input  logic [(1<<SW)-1:0][W-1:0] cand,
  input  logic [SW-1:0]             sel,
  output logic [W-1:0]              y
);
  localparam int N = 1 << SW;

  logic [W-1:0] node [1:2*N-1];

  for (genvar k = 0; k < N; k++) begin : g_leaf
    assign node[N+k] = cand[k];
  end

  for (genvar i = 1; i < N; i++) begin : g_mux
    localparam int DEPTH = $clog2(i + 1) - 1;
    assign node[i] = sel[SW-1-DEPTH] ? node[2*i+1] : node[2*i];
  end

  assign y = node[1];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W  = 8,
  parameter int MW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           cout,
  output logic           bout
);
  logic [NOPS-1:0][W-1:0] cand;
  logic [W-1:0] as_sum, mul_p, pick;
  logic         as_c, is_sub, c_nxt, b_nxt;

  assign is_sub = (op == OP_SUB);

  alu8_addsub #(.W(W)) u_as (
    .x(a), .y(b), .sub(is_sub), .sum(as_sum), .c_out(as_c)
  );

  alu8_nibmul #(.W(W), .MW(MW)) u_mul (
    .x(a), .y(b), .prod(mul_p)
  );

  always_comb begin
    cand[OP_PASS] = b;
    cand[OP_XOR]  = a ^ b;
    cand[OP_AND]  = a & b;
    cand[OP_OR]   = a | b;
    cand[OP_ADD]  = as_sum;
    cand[OP_SUB]  = as_sum;
    cand[OP_SHR]  = {1'b0, b[W-1:1]};
    cand[OP_MUL]  = mul_p;
  end

  alu8_seltree #(.W(W), .SW(OPW)) u_sel (
    .cand(cand), .sel(op), .y(pick)
  );

  assign c_nxt = (op == OP_ADD) & as_c;
  assign b_nxt = is_sub & ~as_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      res  <= '0;
      cout <= 1'b0;
      bout <= 1'b0;
    end else begin
      res  <= pick;
      cout <= c_nxt;
      bout <= b_nxt;
    end
  end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int W  = 8,
  parameter int MW = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] res,
  input logic         cout,
  input logic         bout
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res == '0 && !cout && !bout));

  // R3
  pass_b_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) == 3'b000) |-> res == $past(b));

  // R5
  add_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) == 3'b100) |->
      {cout, res} == ({1'b0, $past(a)} + {1'b0, $past(b)}));

  // R6
  sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) == 3'b101) |-> bout == ($past(b) > $past(a)));

  // R7
  shift_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) == 3'b110) |->
      (!res[W-1] && res[W-2:0] == $past(b[W-1:1])));

  // R9
  carry_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) != 3'b100) |-> !cout);

  // R9
  borrow_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) != 3'b101) |-> !bout);
endmodule

bind alu8_core alu8_chk #(.W(W), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .op(op), .a(a), .b(b),
  .res(res), .cout(cout), .bout(bout)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] op;
  logic [7:0] a, b;
  logic [7:0] res;
  logic       cout, bout;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst(rst), .op(op), .a(a), .b(b),
    .res(res), .cout(cout), .bout(bout)
  );

  function automatic logic [9:0] model(input logic [2:0] o,
                                       input logic [7:0] x, input logic [7:0] y);
    logic [8:0] s;
    case (o)
      3'd0: return {2'b00, y};
      3'd1: return {2'b00, x ^ y};
      3'd2: return {2'b00, x & y};
      3'd3: return {2'b00, x | y};
      3'd4: begin s = {1'b0, x} + {1'b0, y}; return {1'b0, s}; end
      3'd5: return {(y > x), 1'b0, 8'(x - y)};
      3'd6: return {2'b00, y >> 1};
      default: return {2'b00, 8'({4'b0, x[3:0]} * {4'b0, y[3:0]})};
    endcase
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1, 3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic cmp(input string r, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got {bout,cout,res}=%b_%b_%h expected %b_%b_%h",
               r, got[9], got[8], got[7:0], exp[9], exp[8], exp[7:0]);
    end
  endtask

  // drive on falling edge, sample one cycle later on the next falling edge (R2)
  task automatic run(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y,
                     input string r);
    op = o; a = x; b = y;
    @(negedge clk);
    cmp(r, {bout, cout, res}, model(o, x, y));
    // R9: flags of other codes are covered by the model's zero flags
  endtask

  task automatic grab(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y,
                      output logic [9:0] v);
    op = o; a = x; b = y;
    @(negedge clk);
    v = {bout, cout, res};
  endtask

  initial begin
    logic [9:0] v1, v2;
    void'($urandom(32'h5eed1));
    rst = 1'b1; op = 3'd4; a = 8'hFF; b = 8'hFF;
    repeat (2) @(negedge clk);
    cmp("R1", {bout, cout, res}, 10'd0);
    rst = 1'b0;

    // R10 directed sequence
    begin
      logic [7:0] expv [8] = '{8'hAA, 8'h00, 8'hAA, 8'hAA, 8'h54, 8'h00, 8'h55, 8'h64};
      for (int k = 0; k < 8; k++) begin
        op = 3'(k); a = 8'hAA; b = 8'hAA;
        @(negedge clk);
        cmp("R10", {bout, cout, res}, {1'b0, (k == 4), expv[k]});
      end
    end

    // corners for add/sub
    run(3'd4, 8'hFF, 8'h01, "R5");
    run(3'd4, 8'h00, 8'h00, "R5");
    run(3'd4, 8'hFF, 8'hFF, "R5");
    run(3'd5, 8'h00, 8'h01, "R6");
    run(3'd5, 8'h7F, 8'h80, "R6");
    run(3'd5, 8'h33, 8'h33, "R6");
    run(3'd5, 8'hFF, 8'h00, "R6");
    run(3'd7, 8'hFF, 8'hFF, "R8");
    run(3'd6, 8'hFF, 8'h01, "R7");

    // ignored bits: A on pass and shift, upper nibbles on multiply
    grab(3'd6, 8'h00, 8'hC3, v1); grab(3'd6, 8'hFF, 8'hC3, v2);
    cmp("R7", v2, v1);
    grab(3'd0, 8'h00, 8'h5A, v1); grab(3'd0, 8'hFF, 8'h5A, v2);
    cmp("R3", v2, v1);
    grab(3'd7, 8'h0D, 8'h0B, v1); grab(3'd7, 8'hAD, 8'h7B, v2);
    cmp("R8", v2, v1);
    cmp("R8", v1, 10'd143);

    // back-to-back random operations, every code (R2, R9)
    for (int n = 0; n < 800; n++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      run(o, 8'($urandom), 8'($urandom), tag(o));
    end

    // R1 again mid-run
    op = 3'd5; a = 8'h00; b = 8'hFF; rst = 1'b1;
    @(negedge clk);
    cmp("R1", {bout, cout, res}, 10'd0);
    rst = 1'b0;

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule